// File: doc/BRIEF.md
# Commit-Time Register Value Merge Checker

In a multi-threaded core that fetches identical instruction streams for several threads at once, a per-register sharing table records which thread pairs hold the same value in each architected register. When threads run on different paths for a while, those sharing bits are cleared even if both paths end up writing the same value. This block lets the core recover that lost sharing. It keeps its own copy of each thread's rename map and a per-thread "quiet" bit for every architected register. The quiet bit means no instruction is currently in flight to that register. The main alias table gains no read ports.

When an instruction commits, the block checks whether the architected destination still maps to the physical tag being written. Only instructions fetched while the threads were apart (the divergent or catch-up fetch modes, shown by one input flag) go on to the next step. For those, the block borrows spare register-file read ports. With them it reads the same architected register of every other thread whose register is quiet. One cycle later it compares each value read with the committed value. Each match produces a set request for the matching thread pair in the external sharing table.

Comparisons are opportunistic. A comparison that finds no free port is dropped and never retried. Dropping it only loses a chance to restore sharing and never makes the sharing table wrong.

Top module: `reg_merge_checker`

## Requirements
- R1: After reset every quiet bit is 1, and architected register a of every thread maps to physical tag a in the private map. No read request and no sharing write is active.
- R2: A rename (`ren_valid`) of thread t, register a, to tag p stores p as t's mapping for a and clears t's quiet bit for a.
- R3: A commit whose tag equals the thread's current private mapping for its register sets that thread's quiet bit. A commit with any other tag leaves the quiet bit and the map unchanged and issues no read.
- R4: A commit with `cmt_track` low issues no reads and no sharing write, but still sets the quiet bit when its mapping is valid.
- R5: A tracked commit with a valid mapping issues reads in the commit cycle to the other threads whose quiet bit is 1. The threads are taken in ascending thread order. Read slot k carries the k-th such thread, and `rd_tag` is that thread's mapped tag. `rd_en` fills from slot 0 upward.
- R6: At most min(`rf_free_ports`, MAX_PORTS) reads are issued. Threads beyond that limit are skipped and are not compared later.
- R7: One cycle after the reads, `rd_data` is compared with the committed value. If any slot matches, `sh_wr_en` is high and `sh_wr_areg` holds the committed register. In `sh_wr_pairs`, bit i*(2N-i-1)/2 + (j-i-1) stands for the pair i<j (for N=4: 01→0, 02→1, 03→2, 12→3, 13→4, 23→5). That bit is 1 for each matching pair of the committing thread. With no match, `sh_wr_en` stays low.
- R8: A rename in the same cycle as a commit takes priority. A same-cycle rename of the same thread and register leaves the quiet bit at 0. A same-cycle rename of another thread to the committed register excludes that thread from the reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ren_valid | input | 1 | A physical destination is being assigned |
| ren_thr | input | 2 | Thread of the rename |
| ren_areg | input | 6 | Architected destination of the rename |
| ren_ptag | input | 9 | New physical tag |
| cmt_valid | input | 1 | An instruction with a destination commits |
| cmt_thr | input | 2 | Committing thread |
| cmt_areg | input | 6 | Architected destination of the commit |
| cmt_ptag | input | 9 | Physical tag written by the commit |
| cmt_data | input | 32 | Committed value |
| cmt_track | input | 1 | Instruction was fetched in divergent or catch-up mode |
| rf_free_ports | input | 2 | Register-file read ports free this cycle |
| rd_en | output | 3 | Read request per slot |
| rd_tag | output | 27 | Physical tag per slot, slot k in bits [9k+8:9k] |
| rd_data | input | 96 | Read data one cycle after the request, slot k in bits [32k+31:32k] |
| sh_wr_en | output | 1 | Sharing-table set request |
| sh_wr_areg | output | 6 | Architected register to update |
| sh_wr_pairs | output | 6 | Thread-pair bits to set |

## Verification
Wrong quiet-bit or private-map state inside the block shows up at the read-request ports in the very cycle of the next tracked commit on that register. A thread appears in the wrong slot, is missing, or appears with a stale tag. Errors in the compare stage show up exactly one cycle later as a wrong pair mask, a wrong register, or a missing or spurious `sh_wr_en`. The bench therefore keeps an independent model of maps and quiet bits. After every step it checks the read slots in the commit cycle and the sharing write in the cycle after.

// File: rtl/mrg_pkg.sv
package mrg_pkg;

   // index of the unordered thread pair (i<j) among n threads
   function automatic int pair_idx(input int i, input int j, input int n);
      return (i * (2 * n - i - 1)) / 2 + (j - i - 1);
   endfunction

   // mask of every pair bit that involves thread t
   function automatic logic [63:0] pair_mask(input int t, input int n);
      logic [63:0] m;
      m = '0;
      for (int o = 0; o < n; o++) begin
         if (o < t) m[pair_idx(o, t, n)] = 1'b1;
         else if (o > t) m[pair_idx(t, o, n)] = 1'b1;
      end
      return m;
   endfunction

endpackage

// File: rtl/mrg_thread_state.sv
module mrg_thread_state #(
   parameter int NUM_AREG = 50,
   parameter int PTAG_W   = 9,
   localparam int AREG_W  = $clog2(NUM_AREG)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              ren_we,
   input  logic [AREG_W-1:0] ren_areg,
   input  logic [PTAG_W-1:0] ren_ptag,
   input  logic              done_we,
   input  logic [AREG_W-1:0] done_areg,
   input  logic [AREG_W-1:0] look_areg,
   output logic              look_quiet,
   output logic [PTAG_W-1:0] look_ptag
);

   logic [NUM_AREG-1:0] quiet_q;
   logic [PTAG_W-1:0]   map_q [NUM_AREG];

   always_ff @(posedge clk) begin
      if (rst) begin
         quiet_q <= '1;
         for (int a = 0; a < NUM_AREG; a++) map_q[a] <= PTAG_W'(a);
      end else begin
         if (done_we)  quiet_q[done_areg] <= 1'b1;
         if (ren_we) begin
            quiet_q[ren_areg] <= 1'b0;
            map_q[ren_areg]   <= ren_ptag;
         end
      end
   end

   assign look_quiet = quiet_q[look_areg];
   assign look_ptag  = map_q[look_areg];

endmodule

// File: rtl/mrg_port_alloc.sv
module mrg_port_alloc #(
   parameter int NUM_THR   = 4,
   parameter int MAX_PORTS = 3,
   localparam int THR_W    = $clog2(NUM_THR),
   localparam int FREE_W   = $clog2(MAX_PORTS + 1)
) (
   input  logic [NUM_THR-1:0]               cand,
   input  logic [FREE_W-1:0]                free_ports,
   output logic [MAX_PORTS-1:0]             slot_en,
   output logic [MAX_PORTS-1:0][THR_W-1:0]  slot_thr
);

   int lim;
   int used;

   always_comb begin
      lim      = (int'(free_ports) < MAX_PORTS) ? int'(free_ports) : MAX_PORTS;
      used     = 0;
      slot_en  = '0;
      slot_thr = '0;
      for (int t = 0; t < NUM_THR; t++) begin
         if (cand[t] && used < lim) begin
            slot_en[used]  = 1'b1;
            slot_thr[used] = THR_W'(t);
            used           = used + 1;
         end
      end
   end

endmodule

// File: rtl/mrg_compare.sv
module mrg_compare #(
   parameter int NUM_THR   = 4,
   parameter int MAX_PORTS = 3,
   parameter int DATA_W    = 32,
   parameter int NUM_AREG  = 50,
   localparam int THR_W    = $clog2(NUM_THR),
   localparam int AREG_W   = $clog2(NUM_AREG),
   localparam int PAIRS    = NUM_THR * (NUM_THR - 1) / 2
) (
   input  logic                             clk,
   input  logic                             rst,
   input  logic [MAX_PORTS-1:0]             req_en,
   input  logic [MAX_PORTS-1:0][THR_W-1:0]  req_thr,
   input  logic [THR_W-1:0]                 own_thr,
   input  logic [AREG_W-1:0]                own_areg,
   input  logic [DATA_W-1:0]                own_data,
   input  logic [MAX_PORTS*DATA_W-1:0]      rd_data,
   output logic                             sh_wr_en,
   output logic [AREG_W-1:0]                sh_wr_areg,
   output logic [PAIRS-1:0]                 sh_wr_pairs
);
   import mrg_pkg::*;

   logic [MAX_PORTS-1:0]            s2_en;
   logic [MAX_PORTS-1:0][THR_W-1:0] s2_thr;
   logic [THR_W-1:0]                s2_own;
   logic [AREG_W-1:0]               s2_areg;
   logic [DATA_W-1:0]               s2_data;
   logic [MAX_PORTS-1:0]            hit;

   always_ff @(posedge clk) begin
      if (rst) begin
         s2_en   <= '0;
         s2_thr  <= '0;
         s2_own  <= '0;
         s2_areg <= '0;
         s2_data <= '0;
      end else begin
         s2_en   <= req_en;
         s2_thr  <= req_thr;
         s2_own  <= own_thr;
         s2_areg <= own_areg;
         s2_data <= own_data;
      end
   end

   for (genvar p = 0; p < MAX_PORTS; p++) begin : g_cmp
      assign hit[p] = s2_en[p] && (rd_data[p*DATA_W +: DATA_W] == s2_data);
   end

   always_comb begin
      sh_wr_pairs = '0;
      for (int p = 0; p < MAX_PORTS; p++) begin
         if (hit[p]) begin
            if (int'(s2_thr[p]) < int'(s2_own))
               sh_wr_pairs[pair_idx(int'(s2_thr[p]), int'(s2_own), NUM_THR)] = 1'b1;
            else
               sh_wr_pairs[pair_idx(int'(s2_own), int'(s2_thr[p]), NUM_THR)] = 1'b1;
         end
      end
   end

   assign sh_wr_en   = |hit;
   assign sh_wr_areg = s2_areg;

endmodule

// File: rtl/reg_merge_checker.sv
module reg_merge_checker #(
   parameter int NUM_THR   = 4,
   parameter int NUM_AREG  = 50,
   parameter int PTAG_W    = 9,
   parameter int DATA_W    = 32,
   parameter int MAX_PORTS = 3,
   localparam int THR_W    = $clog2(NUM_THR),
   localparam int AREG_W   = $clog2(NUM_AREG),
   localparam int FREE_W   = $clog2(MAX_PORTS + 1),
   localparam int PAIRS    = NUM_THR * (NUM_THR - 1) / 2
) (
   input  logic                        clk,
   input  logic                        rst,
   input  logic                        ren_valid,
   input  logic [THR_W-1:0]            ren_thr,
   input  logic [AREG_W-1:0]           ren_areg,
   input  logic [PTAG_W-1:0]           ren_ptag,
   input  logic                        cmt_valid,
   input  logic [THR_W-1:0]            cmt_thr,
   input  logic [AREG_W-1:0]           cmt_areg,
   input  logic [PTAG_W-1:0]           cmt_ptag,
   input  logic [DATA_W-1:0]           cmt_data,
   input  logic                        cmt_track,
   input  logic [FREE_W-1:0]           rf_free_ports,
   output logic [MAX_PORTS-1:0]        rd_en,
   output logic [MAX_PORTS*PTAG_W-1:0] rd_tag,
   input  logic [MAX_PORTS*DATA_W-1:0] rd_data,
   output logic                        sh_wr_en,
   output logic [AREG_W-1:0]           sh_wr_areg,
   output logic [PAIRS-1:0]            sh_wr_pairs
);

   initial begin
      assert (NUM_THR >= 2 && NUM_THR <= 11) else $fatal(1, "NUM_THR out of range");
      assert (NUM_THR == (1 << THR_W)) else $fatal(1, "NUM_THR must be a power of two");
      assert (MAX_PORTS >= 1 && MAX_PORTS <= NUM_THR - 1) else $fatal(1, "MAX_PORTS out of range");
      assert (NUM_AREG >= 2 && NUM_AREG <= (1 << PTAG_W)) else $fatal(1, "NUM_AREG exceeds tag space");
   end

   logic [NUM_THR-1:0]              thr_quiet;
   logic [NUM_THR-1:0][PTAG_W-1:0]  thr_ptag;
   logic [NUM_THR-1:0]              ren_we;
   logic [NUM_THR-1:0]              done_we;
   logic [NUM_THR-1:0]              cand;
   logic                            map_ok;
   logic                            check_go;
   logic [MAX_PORTS-1:0]            slot_en;
   logic [MAX_PORTS-1:0][THR_W-1:0] slot_thr;

   assign map_ok   = cmt_valid && (thr_ptag[cmt_thr] == cmt_ptag);
   assign check_go = map_ok && cmt_track;

   for (genvar t = 0; t < NUM_THR; t++) begin : g_thr
      assign ren_we[t]  = ren_valid && (ren_thr == THR_W'(t));
      assign done_we[t] = map_ok && (cmt_thr == THR_W'(t));
      assign cand[t]    = check_go && thr_quiet[t] && (cmt_thr != THR_W'(t))
                          && !(ren_we[t] && ren_areg == cmt_areg);

      mrg_thread_state #(
         .NUM_AREG (NUM_AREG),
         .PTAG_W   (PTAG_W)
      ) u_state (
         .clk        (clk),
         .rst        (rst),
         .ren_we     (ren_we[t]),
         .ren_areg   (ren_areg),
         .ren_ptag   (ren_ptag),
         .done_we    (done_we[t]),
         .done_areg  (cmt_areg),
         .look_areg  (cmt_areg),
         .look_quiet (thr_quiet[t]),
         .look_ptag  (thr_ptag[t])
      );
   end

   mrg_port_alloc #(
      .NUM_THR   (NUM_THR),
      .MAX_PORTS (MAX_PORTS)
   ) u_alloc (
      .cand       (cand),
      .free_ports (rf_free_ports),
      .slot_en    (slot_en),
      .slot_thr   (slot_thr)
   );

   for (genvar p = 0; p < MAX_PORTS; p++) begin : g_port
      assign rd_tag[p*PTAG_W +: PTAG_W] = slot_en[p] ? thr_ptag[slot_thr[p]] : '0;
   end
   assign rd_en = slot_en;

   mrg_compare #(
      .NUM_THR   (NUM_THR),
      .MAX_PORTS (MAX_PORTS),
      .DATA_W    (DATA_W),
      .NUM_AREG  (NUM_AREG)
   ) u_cmp (
      .clk         (clk),
      .rst         (rst),
      .req_en      (slot_en),
      .req_thr     (slot_thr),
      .own_thr     (cmt_thr),
      .own_areg    (cmt_areg),
      .own_data    (cmt_data),
      .rd_data     (rd_data),
      .sh_wr_en    (sh_wr_en),
      .sh_wr_areg  (sh_wr_areg),
      .sh_wr_pairs (sh_wr_pairs)
   );

endmodule

module reg_merge_checker_sva #(
   parameter int NUM_THR   = 4,
   parameter int NUM_AREG  = 50,
   parameter int MAX_PORTS = 3,
   localparam int THR_W    = $clog2(NUM_THR),
   localparam int AREG_W   = $clog2(NUM_AREG),
   localparam int FREE_W   = $clog2(MAX_PORTS + 1),
   localparam int PAIRS    = NUM_THR * (NUM_THR - 1) / 2
) (
   input logic                 clk,
   input logic                 rst,
   input logic                 cmt_valid,
   input logic                 cmt_track,
   input logic [THR_W-1:0]     cmt_thr,
   input logic [AREG_W-1:0]    cmt_areg,
   input logic [FREE_W-1:0]    rf_free_ports,
   input logic [MAX_PORTS-1:0] rd_en,
   input logic                 sh_wr_en,
   input logic [AREG_W-1:0]    sh_wr_areg,
   input logic [PAIRS-1:0]     sh_wr_pairs
);
   import mrg_pkg::*;

   assert_read_limit_R6: assert property (@(posedge clk) disable iff (rst)
      $countones(rd_en) <= int'(rf_free_ports));

   assert_read_packed_R5: assert property (@(posedge clk) disable iff (rst)
      (rd_en & (rd_en + 1'b1)) == '0);

   assert_untracked_quiet_R4: assert property (@(posedge clk) disable iff (rst)
      !(cmt_valid && cmt_track) |-> rd_en == '0);

   assert_write_follows_read_R7: assert property (@(posedge clk) disable iff (rst)
      !(|rd_en) |=> !sh_wr_en);

   assert_write_target_R7: assert property (@(posedge clk) disable iff (rst)
      (|rd_en) |=> (!sh_wr_en || (sh_wr_areg == $past(cmt_areg)
         && (sh_wr_pairs & ~PAIRS'(pair_mask(int'($past(cmt_thr)), NUM_THR))) == '0)));

endmodule

bind reg_merge_checker reg_merge_checker_sva #(
   .NUM_THR   (NUM_THR),
   .NUM_AREG  (NUM_AREG),
   .MAX_PORTS (MAX_PORTS)
) u_sva (
   .clk           (clk),
   .rst           (rst),
   .cmt_valid     (cmt_valid),
   .cmt_track     (cmt_track),
   .cmt_thr       (cmt_thr),
   .cmt_areg      (cmt_areg),
   .rf_free_ports (rf_free_ports),
   .rd_en         (rd_en),
   .sh_wr_en      (sh_wr_en),
   .sh_wr_areg    (sh_wr_areg),
   .sh_wr_pairs   (sh_wr_pairs)
);

// File: tb/reg_merge_checker_test.sv
module reg_merge_checker_test;
   localparam int N  = 4;
   localparam int NA = 50;
   localparam int PW = 9;
   localparam int DW = 32;
   localparam int MP = 3;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic ren_valid = 0; logic [1:0] ren_thr = 0; logic [5:0] ren_areg = 0; logic [PW-1:0] ren_ptag = 0;
   logic cmt_valid = 0; logic [1:0] cmt_thr = 0; logic [5:0] cmt_areg = 0; logic [PW-1:0] cmt_ptag = 0;
   logic [DW-1:0] cmt_data = 0; logic cmt_track = 0; logic [1:0] rf_free_ports = 0;
   logic [MP-1:0] rd_en; logic [MP*PW-1:0] rd_tag; logic [MP*DW-1:0] rd_data;
   logic sh_wr_en; logic [5:0] sh_wr_areg; logic [5:0] sh_wr_pairs;

   always #4 clk = ~clk;

   reg_merge_checker uut (
      .clk(clk), .rst(rst),
      .ren_valid(ren_valid), .ren_thr(ren_thr), .ren_areg(ren_areg), .ren_ptag(ren_ptag),
      .cmt_valid(cmt_valid), .cmt_thr(cmt_thr), .cmt_areg(cmt_areg), .cmt_ptag(cmt_ptag),
      .cmt_data(cmt_data), .cmt_track(cmt_track), .rf_free_ports(rf_free_ports),
      .rd_en(rd_en), .rd_tag(rd_tag), .rd_data(rd_data),
      .sh_wr_en(sh_wr_en), .sh_wr_areg(sh_wr_areg), .sh_wr_pairs(sh_wr_pairs));

   // register file model: one cycle read latency
   logic [DW-1:0] rf [512];
   logic [MP*DW-1:0] rd_q = '0;
   always @(posedge clk)
      for (int p = 0; p < MP; p++) rd_q[p*DW +: DW] <= rf[rd_tag[p*PW +: PW]];
   assign rd_data = rd_q;

   // requirement model
   int m_map [N][NA];
   bit m_quiet [N][NA];
   int n_chk = 0;
   int n_bad = 0;

   function automatic int pidx(int a, int b);
      int k = 0;
      for (int i = 0; i < N; i++)
         for (int j = i + 1; j < N; j++) begin
            if ((i == a && j == b) || (i == b && j == a)) return k;
            k++;
         end
      return -1;
   endfunction

   task automatic check(string req, string what, longint act, longint exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   // one cycle of stimulus, entered and left at a negedge
   task automatic step(string req, bit rv, int rt, int ra, int rp,
                       bit cv, int ct, int ca, int cp, int cd, bit tr, int fr);
      bit ok; int lim; int used; int e_thr [MP]; bit [MP-1:0] e_en; int e_pairs; bit any;
      ren_valid = rv; ren_thr = 2'(rt); ren_areg = 6'(ra); ren_ptag = PW'(rp);
      cmt_valid = cv; cmt_thr = 2'(ct); cmt_areg = 6'(ca); cmt_ptag = PW'(cp);
      cmt_data = DW'(cd); cmt_track = tr; rf_free_ports = 2'(fr);
      ok = cv && (m_map[ct][ca] == cp);
      lim = (fr < MP) ? fr : MP; used = 0; e_en = '0;
      for (int t = 0; t < N; t++) begin
         if (ok && tr && t != ct && m_quiet[t][ca] && !(rv && rt == t && ra == ca) && used < lim) begin
            e_en[used] = 1'b1; e_thr[used] = t; used++;
         end
      end
      #1;
      check(req, "rd_en", rd_en, e_en);
      for (int p = 0; p < MP; p++)
         if (e_en[p]) check(req, "rd_tag", rd_tag[p*PW +: PW], m_map[e_thr[p]][ca]);
      e_pairs = 0; any = 0;
      for (int p = 0; p < MP; p++)
         if (e_en[p] && rf[m_map[e_thr[p]][ca]] == DW'(cd)) begin
            e_pairs |= (1 << pidx(ct, e_thr[p])); any = 1;
         end
      if (ok) m_quiet[ct][ca] = 1;
      if (rv) begin m_quiet[rt][ra] = 0; m_map[rt][ra] = rp; end
      @(negedge clk);
      check(req, "sh_wr_en", sh_wr_en, any);
      if (any) begin
         check(req, "sh_wr_areg", sh_wr_areg, ca);
         check(req, "sh_wr_pairs", sh_wr_pairs, e_pairs);
      end
      ren_valid = 0; cmt_valid = 0; cmt_track = 0;
   endtask

   task automatic ren(string req, int t, int a, int p);
      step(req, 1, t, a, p, 0, 0, 0, 0, 0, 0, 3);
   endtask
   task automatic cmt(string req, int t, int a, int p, int d, bit tr, int fr);
      step(req, 0, 0, 0, 0, 1, t, a, p, d, tr, fr);
   endtask

   task automatic t_reset;
      check("R1", "rd_en after reset", rd_en, 0);
      check("R1", "sh_wr_en after reset", sh_wr_en, 0);
      rf[5] = 32'h1234;
      cmt("R1", 0, 5, 5, 32'h1234, 1, 3);   // all threads read tag 5, pairs 01,02,03
   endtask

   task automatic t_rename_skip;
      rf[101] = 32'hAA; rf[7] = 32'hAA;
      ren("R2", 1, 7, 100);
      ren("R2", 0, 7, 101);
      cmt("R2", 0, 7, 101, 32'hAA, 1, 3);   // thread 1 pending -> skipped
   endtask

   task automatic t_mismatch;
      rf[100] = 32'hAA; rf[7] = 32'h55;
      cmt("R7", 1, 7, 100, 32'hAA, 1, 3);   // only thread 0 matches -> pair 01
      cmt("R7", 2, 7, 7, 32'h77, 1, 3);     // nothing matches
   endtask

   task automatic t_stale;
      ren("R3", 2, 9, 200);
      ren("R3", 2, 9, 201);
      cmt("R3", 2, 9, 200, 32'h9, 1, 3);    // stale tag: no reads
      rf[9] = 32'h9;
      cmt("R3", 3, 9, 9, 32'h9, 1, 3);      // thread 2 still pending
      rf[201] = 32'h9;
      cmt("R3", 2, 9, 201, 32'h9, 1, 3);    // valid now
   endtask

   task automatic t_untracked;
      ren("R4", 3, 11, 300);
      rf[300] = 32'h33; rf[11] = 32'h33;
      cmt("R4", 3, 11, 300, 32'h33, 0, 3);  // no reads, bit restored
      cmt("R4", 0, 11, 11, 32'h33, 1, 3);   // thread 3 visible again
   endtask

   task automatic t_ports;
      rf[12] = 32'h12;
      cmt("R6", 2, 12, 12, 32'h12, 1, 1);   // only thread 0
      cmt("R6", 2, 12, 12, 32'h12, 1, 0);   // no port, dropped
      cmt("R6", 0, 12, 12, 32'h12, 1, 2);   // threads 1 and 2
      cmt("R5", 3, 12, 12, 32'h12, 1, 3);   // ascending 0,1,2
   endtask

   task automatic t_collide;
      rf[13] = 32'h13;
      step("R8", 1, 1, 13, 400, 1, 0, 13, 13, 32'h13, 1, 3);  // thread 1 excluded
      ren("R8", 2, 14, 410);
      rf[410] = 32'h14; rf[14] = 32'h14;
      step("R8", 1, 2, 14, 411, 1, 2, 14, 410, 32'h14, 1, 3); // rename wins, stays pending
      cmt("R8", 0, 14, 14, 32'h14, 1, 3);                     // thread 2 skipped
   endtask

   bit done = 0;
   initial begin
      #(8 * 200000);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 512; i++) rf[i] = 32'hDEAD_0000 + i;
      for (int t = 0; t < N; t++)
         for (int a = 0; a < NA; a++) begin m_map[t][a] = a; m_quiet[t][a] = 1; end
      repeat (4) @(negedge clk);
      rst = 0;
      @(negedge clk);
      t_reset();
      t_rename_skip();
      t_mismatch();
      t_stale();
      t_untracked();
      t_ports();
      t_collide();
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule